// File: doc/BRIEF.md
# Precise Exception Ordering Tracker

This block handles exceptions for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). A fault is not acted on when a stage reports it. The fault is written into a small status record that travels with the instruction through the stage registers. Only when the instruction reaches writeback does the block look at that record. A faulting instruction at writeback is therefore always the oldest one in flight. Because of this, faults are taken in program order. This holds even when a younger instruction reports its fault several cycles before an older one.

When writeback holds a faulting instruction, the block cancels that instruction's register write. In the same cycle it turns every younger slot into a bubble and cancels a memory write that any of them would make. On the next cycle it raises a one-cycle redirect toward a fixed handler address. Along with the redirect it provides the faulting PC and a two-bit cause. The surrounding core issues one instruction per cycle into fetch and drives the per-stage fault lines. It uses the write enables from this block in place of its own.

Top module: `exc_order_tracker`

## Requirements
- R1: After reset, `commit_o`, `flush_o`, `redirect_o`, `mem_we_o` and `rf_we_o` are 0, `cause_o` is 2'b00 and `epc_o` is 0.
- R2: An instruction issued in cycle c with no fault reaches writeback in cycle c+5. In that cycle `commit_o` is 1, `wb_pc_o` shows its PC, and `rf_we_o` equals its register-write flag. Instructions commit in issue order.
- R3: A fetch page fault (`if_fault_i` high in cycle c+1, while the instruction is in fetch) is taken at writeback with cause 2'b01. No register write and no commit happen for that instruction.
- R4: An illegal-opcode report (`id_illegal_i` high in cycle c+2, in decode) is taken at writeback with cause 2'b11.
- R5: A data page fault (`mem_fault_i` high in cycle c+4, in the memory stage) is taken at writeback with cause 2'b10. If that instruction is a store, `mem_we_o` stays 0 in the faulting cycle.
- R6: Only the first fault recorded for an instruction is kept. An instruction that faults in fetch and again later reports cause 2'b01.
- R7: An older instruction's memory-stage fault and a younger instruction's fetch fault can arrive in the same cycle. In that case only the older fault is taken (its PC, cause 2'b10). The younger fault never produces a redirect.
- R8: In the cycle an exception is taken, `flush_o` is 1. In that cycle `commit_o`, `rf_we_o` and `mem_we_o` are 0, including for a younger store in the memory stage. No flushed instruction commits afterwards.
- R9: One cycle after a taken exception, `redirect_o` is high for exactly one cycle. `epc_o` holds the faulting PC, `cause_o` its cause, and `handler_pc_o` the fixed handler address.
- R10: Fault inputs reported against an empty slot (a bubble) have no effect. They cause no flush and no redirect, `epc_o` and `cause_o` keep their values, and valid neighbours still commit.
- R11: A fault-free store in the memory stage drives `mem_we_o` high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | An instruction enters fetch at the next edge |
| issue_pc_i | input | PC_W | PC of the issued instruction |
| issue_store_i | input | 1 | Issued instruction is a store |
| issue_wr_i | input | 1 | Issued instruction writes a register |
| if_fault_i | input | 1 | Page fault for the instruction now in fetch |
| id_illegal_i | input | 1 | Illegal opcode for the instruction now in decode |
| mem_fault_i | input | 1 | Data page fault for the instruction now in the memory stage |
| mem_we_o | output | 1 | Qualified memory write strobe for the memory stage |
| rf_we_o | output | 1 | Qualified register write at writeback |
| commit_o | output | 1 | A fault-free instruction retires this cycle |
| wb_pc_o | output | PC_W | PC of the writeback slot |
| flush_o | output | 1 | Exception taken; younger slots become bubbles |
| redirect_o | output | 1 | One-cycle request to fetch from the handler |
| handler_pc_o | output | PC_W | Fixed handler address |
| epc_o | output | PC_W | PC of the last taken faulting instruction |
| cause_o | output | 2 | Cause of the last taken exception (00 none, 01 fetch page fault, 10 data page fault, 11 illegal) |

## Verification
The hardest case to reach from the ports is the one where order matters. An old store faults in the memory stage in the same cycle that a younger instruction faults in fetch. A second younger store also sits in the memory stage when the exception is taken. The stimulus issues four back-to-back instructions and times the fault lines to each one's stage cycle, so that both faults coincide. It then checks four things: the strobes of both stores stay low, the redirect carries only the older PC, and the younger fault never leads to a second redirect. Bubbles that receive fault pulses are checked the same way, by confirming that the exception registers keep their values.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_IPF  = 2'b01,
    CAUSE_DPF  = 2'b10,
    CAUSE_ILL  = 2'b11
  } cause_e;

  typedef struct packed {
    logic   valid;
    logic   store;
    logic   wr;
    cause_e cause;
  } slot_ctl_t;

  localparam slot_ctl_t SLOT_BUBBLE = '{valid: 1'b0, store: 1'b0, wr: 1'b0, cause: CAUSE_NONE};
endpackage

// File: rtl/exc_fault_merge.sv
`timescale 1ns/1ps
module exc_fault_merge
  import exc_pkg::*;
#(
  parameter cause_e CODE = CAUSE_NONE
) (
  input  slot_ctl_t ctl_i,
  input  logic      raise_i,
  output slot_ctl_t ctl_o
);
  // first recorded fault wins; bubbles never pick up a fault
  always_comb begin
    ctl_o = ctl_i;
    if (ctl_i.valid && raise_i && ctl_i.cause == CAUSE_NONE) ctl_o.cause = CODE;
  end
endmodule

// File: rtl/exc_stage_reg.sv
`timescale 1ns/1ps
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int     PC_W = 32,
  parameter cause_e CODE = CAUSE_NONE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  slot_ctl_t       ctl_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            raise_i,
  output slot_ctl_t       ctl_o,
  output logic [PC_W-1:0] pc_o
);
  slot_ctl_t ctl_nx;

  exc_fault_merge #(.CODE(CODE)) u_merge (
    .ctl_i  (ctl_i),
    .raise_i(raise_i),
    .ctl_o  (ctl_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= SLOT_BUBBLE;
      pc_o  <= '0;
    end else begin
      ctl_o <= flush_i ? SLOT_BUBBLE : ctl_nx;
      pc_o  <= pc_i;
    end
  end
endmodule

// File: rtl/exc_commit_ctl.sv
`timescale 1ns/1ps
module exc_commit_ctl
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  slot_ctl_t       wb_ctl_i,
  input  logic [PC_W-1:0] wb_pc_i,
  output logic            take_o,
  output logic            commit_o,
  output logic            rf_we_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] epc_o,
  output logic [1:0]      cause_o
);
  assign take_o   = wb_ctl_i.valid && (wb_ctl_i.cause != CAUSE_NONE);
  assign commit_o = wb_ctl_i.valid && (wb_ctl_i.cause == CAUSE_NONE);
  assign rf_we_o  = commit_o && wb_ctl_i.wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      epc_o      <= '0;
      cause_o    <= CAUSE_NONE;
    end else begin
      redirect_o <= take_o;
      if (take_o) begin
        epc_o   <= wb_pc_i;
        cause_o <= wb_ctl_i.cause;
      end
    end
  end
endmodule

// File: rtl/exc_order_tracker.sv
`timescale 1ns/1ps
module exc_order_tracker
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter int              N_STAGES   = 5,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_valid_i,
  input  logic [PC_W-1:0] issue_pc_i,
  input  logic            issue_store_i,
  input  logic            issue_wr_i,
  input  logic            if_fault_i,
  input  logic            id_illegal_i,
  input  logic            mem_fault_i,
  output logic            mem_we_o,
  output logic            rf_we_o,
  output logic            commit_o,
  output logic [PC_W-1:0] wb_pc_o,
  output logic            flush_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] handler_pc_o,
  output logic [PC_W-1:0] epc_o,
  output logic [1:0]      cause_o
);
  localparam int ST_IF  = 0;
  localparam int ST_ID  = 1;
  localparam int ST_MEM = N_STAGES - 2;
  localparam int ST_WB  = N_STAGES - 1;

  function automatic cause_e stage_code(input int k);
    if (k == ST_IF)  return CAUSE_IPF;
    if (k == ST_ID)  return CAUSE_ILL;
    if (k == ST_MEM) return CAUSE_DPF;
    return CAUSE_NONE;
  endfunction

  slot_ctl_t          ctl_q [N_STAGES];
  logic [PC_W-1:0]    pc_q  [N_STAGES];
  logic [N_STAGES-2:0] raise;
  logic               take;
  slot_ctl_t          issue_ctl;

  always_comb begin
    raise         = '0;
    raise[ST_IF]  = if_fault_i;
    raise[ST_ID]  = id_illegal_i;
    raise[ST_MEM] = mem_fault_i;
  end

  assign issue_ctl = '{valid: issue_valid_i, store: issue_store_i, wr: issue_wr_i, cause: CAUSE_NONE};

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      exc_stage_reg #(.PC_W(PC_W), .CODE(CAUSE_NONE)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .flush_i(take),
        .ctl_i  (issue_ctl),
        .pc_i   (issue_pc_i),
        .raise_i(1'b0),
        .ctl_o  (ctl_q[k]),
        .pc_o   (pc_q[k])
      );
    end else begin : g_body
      exc_stage_reg #(.PC_W(PC_W), .CODE(stage_code(k-1))) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .flush_i(take),
        .ctl_i  (ctl_q[k-1]),
        .pc_i   (pc_q[k-1]),
        .raise_i(raise[k-1]),
        .ctl_o  (ctl_q[k]),
        .pc_o   (pc_q[k])
      );
    end
  end

  exc_commit_ctl #(.PC_W(PC_W)) u_commit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wb_ctl_i  (ctl_q[ST_WB]),
    .wb_pc_i   (pc_q[ST_WB]),
    .take_o    (take),
    .commit_o  (commit_o),
    .rf_we_o   (rf_we_o),
    .redirect_o(redirect_o),
    .epc_o     (epc_o),
    .cause_o   (cause_o)
  );

  // strobe gated by the recorded vector, the live fault and an older take
  assign mem_we_o = ctl_q[ST_MEM].valid && ctl_q[ST_MEM].store &&
                    (ctl_q[ST_MEM].cause == CAUSE_NONE) && !mem_fault_i && !take;

  assign flush_o      = take;
  assign wb_pc_o      = pc_q[ST_WB];
  assign handler_pc_o = HANDLER_PC;
endmodule

// File: rtl/exc_order_checker.sv
`timescale 1ns/1ps
module exc_order_checker #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_fault_i,
  input logic            mem_we_o,
  input logic            rf_we_o,
  input logic            commit_o,
  input logic [PC_W-1:0] wb_pc_o,
  input logic            flush_o,
  input logic            redirect_o,
  input logic [PC_W-1:0] epc_o,
  input logic [1:0]      cause_o
);
  a_r5_no_we_on_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_fault_i);

  a_r8_take_blocks_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (!mem_we_o && !rf_we_o && !commit_o));

  a_r8_flushed_stay_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (!commit_o && !mem_we_o && !flush_o));

  a_r9_redirect_follows_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (redirect_o && epc_o == $past(wb_pc_o)));

  a_r9_redirect_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);

  a_r9_redirect_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (cause_o != 2'b00));

  a_r2_rf_we_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> commit_o);
endmodule

bind exc_order_tracker exc_order_checker #(.PC_W(PC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_fault_i(mem_fault_i),
  .mem_we_o   (mem_we_o),
  .rf_we_o    (rf_we_o),
  .commit_o   (commit_o),
  .wb_pc_o    (wb_pc_o),
  .flush_o    (flush_o),
  .redirect_o (redirect_o),
  .epc_o      (epc_o),
  .cause_o    (cause_o)
);

// File: tb/sim_exc_order_tracker.sv
`timescale 1ns/1ps
module sim_exc_order_tracker;
  localparam int PC_W = 32;
  localparam int NC   = 16;
  localparam logic [PC_W-1:0] HND = 32'h0000_0080;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic issue_valid_i = 0, issue_store_i = 0, issue_wr_i = 0;
  logic [PC_W-1:0] issue_pc_i = '0;
  logic if_fault_i = 0, id_illegal_i = 0, mem_fault_i = 0;
  logic mem_we_o, rf_we_o, commit_o, flush_o, redirect_o;
  logic [PC_W-1:0] wb_pc_o, handler_pc_o, epc_o;
  logic [1:0] cause_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic s_iv[NC], s_st[NC], s_wr[NC], s_if[NC], s_il[NC], s_mf[NC];
  logic [PC_W-1:0] s_pc[NC];
  logic o_we[NC], o_rf[NC], o_cm[NC], o_fl[NC], o_rd[NC];
  logic [PC_W-1:0] o_pc[NC], o_epc[NC];
  logic [1:0] o_ca[NC];

  always #2.5 clk_i = ~clk_i;

  exc_order_tracker #(.PC_W(PC_W), .HANDLER_PC(HND)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int j = 0; j < NC; j++) begin
      s_iv[j] = 0; s_st[j] = 0; s_wr[j] = 0; s_pc[j] = '0;
      s_if[j] = 0; s_il[j] = 0; s_mf[j] = 0;
    end
  endtask

  task automatic put(input int c, input logic [PC_W-1:0] pc, input logic st, input logic wr);
    s_iv[c] = 1; s_pc[c] = pc; s_st[c] = st; s_wr[c] = wr;
  endtask

  task automatic run();
    for (int j = 0; j < NC; j++) begin
      @(negedge clk_i);
      issue_valid_i = s_iv[j]; issue_pc_i = s_pc[j];
      issue_store_i = s_st[j]; issue_wr_i = s_wr[j];
      if_fault_i = s_if[j]; id_illegal_i = s_il[j]; mem_fault_i = s_mf[j];
      #1;
      o_we[j] = mem_we_o; o_rf[j] = rf_we_o; o_cm[j] = commit_o; o_fl[j] = flush_o;
      o_rd[j] = redirect_o; o_pc[j] = wb_pc_o; o_epc[j] = epc_o; o_ca[j] = cause_o;
    end
    @(negedge clk_i);
    issue_valid_i = 0; if_fault_i = 0; id_illegal_i = 0; mem_fault_i = 0;
  endtask

  function automatic int count_rd();
    int n = 0;
    for (int j = 0; j < NC; j++) n += int'(o_rd[j]);
    return n;
  endfunction

  task automatic t_reset();
    #1;
    chk(!commit_o && !flush_o && !redirect_o && !mem_we_o && !rf_we_o, "R1", "strobes", 0, 0);
    chk(cause_o == 2'b00, "R1", "cause", cause_o, 0);
    chk(epc_o == '0, "R1", "epc", epc_o, 0);
  endtask

  task automatic t_plain();
    clear_stim();
    put(0, 32'h100, 0, 1); put(1, 32'h104, 1, 0); put(2, 32'h108, 0, 0);
    run();
    chk(o_cm[5] && o_pc[5] == 32'h100, "R2", "commit 1st", o_pc[5], 32'h100);
    chk(o_rf[5], "R2", "rf_we 1st", o_rf[5], 1);
    chk(o_cm[6] && o_pc[6] == 32'h104 && !o_rf[6], "R2", "commit store", o_pc[6], 32'h104);
    chk(o_cm[7] && o_pc[7] == 32'h108 && !o_rf[7], "R2", "commit 3rd", o_pc[7], 32'h108);
    chk(!o_cm[4] && !o_cm[8], "R2", "no extra commit", {o_cm[4], o_cm[8]}, 0);
    chk(o_we[5] && !o_we[4] && !o_we[6], "R11", "store strobe", {o_we[4], o_we[5], o_we[6]}, 3'b010);
  endtask

  task automatic t_if_fault();
    clear_stim();
    put(0, 32'h200, 0, 1); put(1, 32'h204, 0, 1); put(2, 32'h208, 0, 1);
    s_if[1] = 1;
    run();
    chk(o_fl[5] && !o_cm[5] && !o_rf[5], "R3", "taken no write", {o_fl[5], o_cm[5], o_rf[5]}, 3'b100);
    chk(!o_cm[6] && !o_cm[7], "R8", "younger flushed", {o_cm[6], o_cm[7]}, 0);
    chk(o_rd[6] && !o_rd[7] && !o_rd[5], "R9", "redirect pulse", {o_rd[5], o_rd[6], o_rd[7]}, 3'b010);
    chk(o_epc[6] == 32'h200, "R9", "epc", o_epc[6], 32'h200);
    chk(o_ca[6] == 2'b01, "R3", "cause", o_ca[6], 2'b01);
    chk(handler_pc_o == HND, "R9", "handler", handler_pc_o, HND);
  endtask

  task automatic t_illegal();
    clear_stim();
    put(0, 32'h300, 0, 1);
    s_il[2] = 1;
    run();
    chk(o_fl[5] && !o_rf[5], "R4", "taken", o_fl[5], 1);
    chk(o_rd[6] && o_ca[6] == 2'b11 && o_epc[6] == 32'h300, "R4", "cause", o_ca[6], 2'b11);
  endtask

  task automatic t_order();
    clear_stim();
    put(0, 32'h400, 1, 0); put(1, 32'h404, 1, 0); put(2, 32'h408, 0, 1); put(3, 32'h40c, 0, 1);
    s_mf[4] = 1; s_if[4] = 1;
    run();
    chk(!o_we[4], "R5", "faulting store strobe", o_we[4], 0);
    chk(!o_we[5] && o_fl[5], "R8", "younger store strobe", o_we[5], 0);
    chk(o_ca[6] == 2'b10 && o_epc[6] == 32'h400, "R7", "older taken", o_epc[6], 32'h400);
    chk(o_ca[6] == 2'b10, "R5", "data fault cause", o_ca[6], 2'b10);
    chk(count_rd() == 1 && o_epc[NC-1] == 32'h400, "R7", "younger never taken", count_rd(), 1);
    chk(!o_cm[6] && !o_cm[7] && !o_cm[8], "R8", "no flushed commit", {o_cm[6], o_cm[7], o_cm[8]}, 0);
  endtask

  task automatic t_first();
    clear_stim();
    put(0, 32'h500, 1, 1);
    s_if[1] = 1; s_il[2] = 1; s_mf[4] = 1;
    run();
    chk(o_ca[6] == 2'b01 && o_epc[6] == 32'h500, "R6", "first fault kept", o_ca[6], 2'b01);
    chk(count_rd() == 1, "R6", "single take", count_rd(), 1);
  endtask

  task automatic t_bubble();
    clear_stim();
    for (int j = 0; j < NC; j++) begin s_if[j] = 1; s_il[j] = 1; s_mf[j] = 1; end
    run();
    chk(count_rd() == 0, "R10", "no redirect on bubbles", count_rd(), 0);
    chk(o_epc[NC-1] == 32'h500 && o_ca[NC-1] == 2'b01, "R10", "exc regs kept", o_epc[NC-1], 32'h500);
    clear_stim();
    put(0, 32'h600, 0, 1); put(2, 32'h608, 0, 1);
    s_if[2] = 1;
    run();
    chk(o_cm[5] && o_pc[5] == 32'h600, "R10", "neighbour commits", o_pc[5], 32'h600);
    chk(o_cm[7] && o_pc[7] == 32'h608 && count_rd() == 0, "R10", "later neighbour", o_pc[7], 32'h608);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_plain();
    t_if_fault();
    t_illegal();
    t_order();
    t_first();
    t_bubble();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule